// File: doc/BRIEF.md
# Clock Interrupt Emulation Engine

This block recreates the interrupt behaviour of a real-time clock on top of a single one-shot comparator and a free-running counter. A steady base tick of 64 Hz is made by keeping a compare value ahead of the counter. Each time the counter reaches it, the compare value moves forward by one interval. On every such tick the block looks at the current time of day and its enable bits. It can raise three kinds of event. An update event fires when the seconds value has moved. An alarm event fires when the time equals a stored alarm time. A periodic event fires at a programmable power-of-two rate.

Periodic rates up to the base tick are made by dividing the tick count. Faster rates shorten the tick interval itself. If the counter has already run past one or more compare points, the compare value steps forward until it is ahead again. The steps skipped this way are reported and credited to the periodic divider. Events collect in a sticky flag word, which software clears with a read-clear strobe. Every event-bearing tick also gives a one-cycle interrupt strobe. The calendar itself (the time-of-day inputs) is kept elsewhere.

Top module: `clk_irq_emul`

## Requirements
- R1: After a synchronous active-low reset, `flag_word`, `irq_strobe`, `cmp_active`, `cmp_value` and `lost_ticks` are all zero.
- R2: When any enable rises from the state where all three are clear, the comparator becomes active and `cmp_value` becomes the counter plus one interval. The interval is `TICKS_PER_SEC >> 6` (1024 by default), or `TICKS_PER_SEC >> k` in fast periodic mode.
- R3: When `upd_en`, `alm_en` and `per_en` are all low, `cmp_active` is low one cycle later, and counter movement produces no strobe.
- R4: A tick occurs when the signed 32-bit difference counter minus `cmp_value` is zero or positive. The compare value then steps by one interval at a time until the signed difference `cmp_value` minus counter is positive. `lost_ticks` reports the number of steps beyond the first, and saturates at its maximum.
- R5: The update flag (bit 4) is raised on a tick when `upd_en` is set and `sec_in` differs from the value recorded at the previous change. The first tick after `upd_en` rises only records the seconds value and raises no flag.
- R6: The alarm flag (bit 5) is raised on a tick when `alm_en` is set and hour, minute and second all equal the alarm inputs.
- R7: The periodic rate is 2^k Hz, with k = `per_rate_log2` clamped to 1..13. For k of 6 or less, the periodic flag (bit 6) is raised on every 2^(6-k)-th tick, and the divider count returns to zero each time the flag fires.
- R8: For k of 7 or more with `per_en` set, the tick interval becomes `TICKS_PER_SEC >> k`, and the periodic flag is raised on every tick.
- R9: When `per_en` is set, the lost ticks of a catch-up are added to the periodic divider count before the count is compared with its limit.
- R10: On a tick that raises any flag, the flag word also gets bit 7 (pending) and the value 1 in bits 15:8, and `irq_strobe` is high for exactly one cycle.
- R11: New flags are ORed into the unacknowledged flag word. `flag_ack` clears it. When `flag_ack` and a new flag land in the same cycle, the word holds only the new flag.
- R12: Comparisons between counter and compare value work across counter wrap: a compare value just past zero is not reached by a counter value just below the wrap point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| counter_in | input | 32 | Free-running main counter |
| sec_in | input | 6 | Current seconds |
| min_in | input | 6 | Current minutes |
| hour_in | input | 5 | Current hours |
| upd_en | input | 1 | Update event enable |
| alm_en | input | 1 | Alarm event enable |
| per_en | input | 1 | Periodic event enable |
| alm_sec | input | 6 | Alarm seconds |
| alm_min | input | 6 | Alarm minutes |
| alm_hour | input | 5 | Alarm hours |
| per_rate_log2 | input | 4 | Periodic rate exponent k (rate 2^k Hz) |
| flag_ack | input | 1 | Read-clear strobe for the flag word |
| flag_word | output | 16 | Sticky flags: 4 update, 5 alarm, 6 periodic, 7 pending, 15:8 count |
| irq_strobe | output | 1 | One-cycle pulse per event-bearing tick |
| cmp_active | output | 1 | Comparator channel armed |
| cmp_value | output | 32 | Current compare value |
| lost_ticks | output | 8 | Extra steps taken at the most recent tick |

## Verification
A corrupted compare value shows up on `cmp_value` at once. The first tick after that then arrives at the wrong counter value or never arrives, so `irq_strobe` goes missing or comes too early within a tick. A wrong periodic divider count or a stale recorded seconds value stays hidden until the next tick. It then shows as a periodic flag that is missing or extra, or an update flag one tick off. Catch-up faults show in `lost_ticks` and in the periodic flag of the same tick. The flag word itself gives away a wrong OR or acknowledge path on the cycle after the strobe.

// File: rtl/clk_irq_pkg.sv
// Shared constants and types for the clock interrupt emulation engine.
// Assumes a 64 Hz base tick (exponent 6) and periodic exponents up to 13.
package clk_irq_pkg;
    localparam int BASE_LOG2 = 6;     // base tick is 2^6 Hz
    localparam int MAX_LOG2  = 13;    // fastest periodic rate 2^13 Hz
    localparam int LIM_W     = BASE_LOG2 + 1;
    localparam int FLAG_W    = 16;
    localparam int UPD_BIT   = 4;
    localparam int ALM_BIT   = 5;
    localparam int PER_BIT   = 6;
    localparam int PEND_BIT  = 7;
    localparam int CNT_LSB   = 8;

    typedef enum logic [1:0] {
        SCH_IDLE  = 2'd0,
        SCH_WAIT  = 2'd1,
        SCH_CATCH = 2'd2
    } sch_state_e;
endpackage

// File: rtl/clk_irq_interval.sv
// Picks the tick interval and the periodic divider limit from the rate exponent.
// Assumes TICKS_PER_SEC >> MAX_LOG2 is at least 1. Purely combinational.
module clk_irq_interval
    import clk_irq_pkg::*;
#(
    parameter int CNT_W         = 32,
    parameter int RATE_W        = 4,
    parameter int TICKS_PER_SEC = 65536
) (
    input  logic              per_en,
    input  logic [RATE_W-1:0] rate_log2,
    output logic [CNT_W-1:0]  interval,
    output logic [LIM_W-1:0]  per_limit
);
    localparam logic [CNT_W-1:0] TPS_V = CNT_W'(TICKS_PER_SEC);

    logic [RATE_W-1:0] rate_q;
    logic              fast;

    // clamp the exponent into the supported range
    always_comb begin
        if (rate_log2 < RATE_W'(1))                   rate_q = RATE_W'(1);
        else if (rate_log2 > RATE_W'(MAX_LOG2))       rate_q = RATE_W'(MAX_LOG2);
        else                                          rate_q = rate_log2;
    end

    // fast rates shorten the interval; slow ones divide the base tick
    always_comb begin
        fast = per_en && (rate_q > RATE_W'(BASE_LOG2));
        if (fast) begin
            interval  = TPS_V >> rate_q;
            per_limit = LIM_W'(1);
        end else begin
            interval  = TPS_V >> BASE_LOG2;
            per_limit = LIM_W'(1) << (RATE_W'(BASE_LOG2) - rate_q);
        end
    end
endmodule

// File: rtl/clk_irq_sched.sv
// Comparator scheduler: arms the compare value, detects ticks with a signed
// wrap-safe difference, and steps the compare value forward one interval per
// cycle until it is ahead of the counter, counting extra steps as lost ticks.
// Assumes the interval is nonzero.
module clk_irq_sched
    import clk_irq_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int LOST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_en,
    input  logic [CNT_W-1:0]  counter,
    input  logic [CNT_W-1:0]  interval,
    output logic              tick_p,
    output logic [LOST_W-1:0] lost_cnt,
    output logic [CNT_W-1:0]  cmp_value,
    output logic              cmp_active
);
    sch_state_e        state_q;
    logic [CNT_W-1:0]  cmp_q;
    logic [CNT_W-1:0]  gap;
    logic              hit;
    logic [LOST_W-1:0] lost_acc_q;
    logic [LOST_W-1:0] lost_q;
    logic              tick_q;

    // counter at or past the compare value, judged by the signed difference
    always_comb begin
        gap = counter - cmp_q;
        hit = ~gap[CNT_W-1];
    end

    // arm, fire and catch-up sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SCH_IDLE;
            cmp_q      <= '0;
            lost_acc_q <= '0;
            lost_q     <= '0;
            tick_q     <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (!any_en) begin
                state_q <= SCH_IDLE;
            end else begin
                case (state_q)
                    SCH_IDLE: begin
                        cmp_q   <= counter + interval;
                        state_q <= SCH_WAIT;
                    end
                    SCH_WAIT: begin
                        if (hit) begin
                            cmp_q      <= cmp_q + interval;
                            lost_acc_q <= '0;
                            state_q    <= SCH_CATCH;
                        end
                    end
                    SCH_CATCH: begin
                        if (hit) begin
                            cmp_q <= cmp_q + interval;
                            if (lost_acc_q != '1) lost_acc_q <= lost_acc_q + 1'b1;
                        end else begin
                            tick_q  <= 1'b1;
                            lost_q  <= lost_acc_q;
                            state_q <= SCH_WAIT;
                        end
                    end
                    default: state_q <= SCH_IDLE;
                endcase
            end
        end
    end

    assign tick_p     = tick_q;
    assign lost_cnt   = lost_q;
    assign cmp_value  = cmp_q;
    assign cmp_active = (state_q != SCH_IDLE);

    // R3
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_en |=> !cmp_active);
    // R2
    arm_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_active) |-> cmp_q == $past(counter) + $past(interval));
    // R4
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_active && $past(cmp_active) && !$stable(cmp_q)) |->
            cmp_q == $past(cmp_q) + $past(interval));
endmodule

// File: rtl/clk_irq_src.sv
// Event sources evaluated on each tick: update (seconds changed since the last
// recorded value), alarm (time equals alarm time) and periodic (divider with
// lost-tick credit). Flags are combinational and valid only while tick_p is high.
module clk_irq_src
    import clk_irq_pkg::*;
#(
    parameter int LOST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_p,
    input  logic [LOST_W-1:0] lost_cnt,
    input  logic              upd_en,
    input  logic              alm_en,
    input  logic              per_en,
    input  logic [5:0]        sec_in,
    input  logic [5:0]        min_in,
    input  logic [4:0]        hour_in,
    input  logic [5:0]        alm_sec,
    input  logic [5:0]        alm_min,
    input  logic [4:0]        alm_hour,
    input  logic [LIM_W-1:0]  per_limit,
    output logic              upd_flag,
    output logic              alm_flag,
    output logic              per_flag
);
    localparam int SUM_W = ((LOST_W > LIM_W) ? LOST_W : LIM_W) + 2;

    logic [5:0]       prev_sec_q;
    logic             prev_ok_q;
    logic [LIM_W-1:0] per_cnt_q;
    logic             sec_moved;
    logic [SUM_W-1:0] per_sum;

    // evaluate the three event conditions for the current tick
    always_comb begin
        sec_moved = !prev_ok_q || (sec_in != prev_sec_q);
        upd_flag  = tick_p && upd_en && prev_ok_q && (sec_in != prev_sec_q);
        alm_flag  = tick_p && alm_en && (sec_in == alm_sec) &&
                    (min_in == alm_min) && (hour_in == alm_hour);
        per_sum   = SUM_W'(per_cnt_q) + SUM_W'(lost_cnt) + SUM_W'(1);
        per_flag  = tick_p && per_en && (per_sum >= SUM_W'(per_limit));
    end

    // record the seconds value seen at each change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sec_q <= '0;
            prev_ok_q  <= 1'b0;
        end else if (!upd_en) begin
            prev_ok_q  <= 1'b0;
        end else if (tick_p && sec_moved) begin
            prev_sec_q <= sec_in;
            prev_ok_q  <= 1'b1;
        end
    end

    // periodic divider: credit the tick plus lost ticks, restart on fire
    always_ff @(posedge clk) begin
        if (!rst_n || !per_en) begin
            per_cnt_q <= '0;
        end else if (tick_p) begin
            per_cnt_q <= per_flag ? '0 : per_sum[LIM_W-1:0];
        end
    end

    // R7
    per_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_cnt_q < LIM_W'(1 << (BASE_LOG2 - 1)));
    // R5
    upd_first_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_p && upd_en && !prev_ok_q) |=> (prev_ok_q && !upd_flag));
endmodule

// File: rtl/clk_irq_emul.sv
// Top of the clock interrupt emulation engine. Derives the tick interval,
// runs the comparator scheduler, evaluates the event sources and keeps a
// sticky flag word with a one-cycle interrupt strobe per event-bearing tick.
module clk_irq_emul
    import clk_irq_pkg::*;
#(
    parameter int CNT_W         = 32,
    parameter int RATE_W        = 4,
    parameter int LOST_W        = 8,
    parameter int TICKS_PER_SEC = 65536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  counter_in,
    input  logic [5:0]        sec_in,
    input  logic [5:0]        min_in,
    input  logic [4:0]        hour_in,
    input  logic              upd_en,
    input  logic              alm_en,
    input  logic              per_en,
    input  logic [5:0]        alm_sec,
    input  logic [5:0]        alm_min,
    input  logic [4:0]        alm_hour,
    input  logic [RATE_W-1:0] per_rate_log2,
    input  logic              flag_ack,
    output logic [FLAG_W-1:0] flag_word,
    output logic              irq_strobe,
    output logic              cmp_active,
    output logic [CNT_W-1:0]  cmp_value,
    output logic [LOST_W-1:0] lost_ticks
);
    logic              any_en;
    logic [CNT_W-1:0]  interval;
    logic [LIM_W-1:0]  per_limit;
    logic              tick_p;
    logic              upd_flag, alm_flag, per_flag, any_flag;
    logic [FLAG_W-1:0] ev_word;
    logic [FLAG_W-1:0] flag_q;
    logic              irq_q;

    assign any_en = upd_en | alm_en | per_en;

    clk_irq_interval #(.CNT_W(CNT_W), .RATE_W(RATE_W), .TICKS_PER_SEC(TICKS_PER_SEC)) u_interval (
        .per_en    (per_en),
        .rate_log2 (per_rate_log2),
        .interval  (interval),
        .per_limit (per_limit)
    );

    clk_irq_sched #(.CNT_W(CNT_W), .LOST_W(LOST_W)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_en     (any_en),
        .counter    (counter_in),
        .interval   (interval),
        .tick_p     (tick_p),
        .lost_cnt   (lost_ticks),
        .cmp_value  (cmp_value),
        .cmp_active (cmp_active)
    );

    clk_irq_src #(.LOST_W(LOST_W)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_p    (tick_p),
        .lost_cnt  (lost_ticks),
        .upd_en    (upd_en),
        .alm_en    (alm_en),
        .per_en    (per_en),
        .sec_in    (sec_in),
        .min_in    (min_in),
        .hour_in   (hour_in),
        .alm_sec   (alm_sec),
        .alm_min   (alm_min),
        .alm_hour  (alm_hour),
        .per_limit (per_limit),
        .upd_flag  (upd_flag),
        .alm_flag  (alm_flag),
        .per_flag  (per_flag)
    );

    // assemble the event word for this tick
    always_comb begin
        any_flag               = upd_flag | alm_flag | per_flag;
        ev_word                = '0;
        ev_word[UPD_BIT]       = upd_flag;
        ev_word[ALM_BIT]       = alm_flag;
        ev_word[PER_BIT]       = per_flag;
        ev_word[PEND_BIT]      = 1'b1;
        ev_word[CNT_LSB +: 8]  = 8'd1;
    end

    // sticky flag word with read-clear, plus the interrupt strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= any_flag;
            if (any_flag)      flag_q <= flag_ack ? ev_word : (flag_q | ev_word);
            else if (flag_ack) flag_q <= '0;
        end
    end

    assign flag_word  = flag_q;
    assign irq_strobe = irq_q;

    // R10
    pend_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_strobe |-> (flag_word[PEND_BIT] && flag_word[CNT_LSB +: 8] == 8'd1));
    // R10
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_strobe |=> !irq_strobe);
    // R11
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ack && !tick_p) |=> flag_word == '0);
endmodule

// File: tb/test_clk_irq_emul.sv
`timescale 1ns/1ps
module test_clk_irq_emul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] counter_in = '0;
    logic [5:0]  sec_in = '0, min_in = '0, alm_sec = '0, alm_min = '0;
    logic [4:0]  hour_in = '0, alm_hour = '0;
    logic        upd_en = 1'b0, alm_en = 1'b0, per_en = 1'b0, flag_ack = 1'b0;
    logic [3:0]  per_rate_log2 = 4'd6;
    logic [15:0] flag_word;
    logic        irq_strobe, cmp_active;
    logic [31:0] cmp_value;
    logic [7:0]  lost_ticks;

    int checks = 0;
    int failures = 0;
    int irq_seen = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    clk_irq_emul i_clk_irq_emul (
        .clk(clk), .rst_n(rst_n), .counter_in(counter_in), .sec_in(sec_in),
        .min_in(min_in), .hour_in(hour_in), .upd_en(upd_en), .alm_en(alm_en),
        .per_en(per_en), .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
        .per_rate_log2(per_rate_log2), .flag_ack(flag_ack), .flag_word(flag_word),
        .irq_strobe(irq_strobe), .cmp_active(cmp_active), .cmp_value(cmp_value),
        .lost_ticks(lost_ticks)
    );

    typedef struct packed {
        logic [31:0] cnt;
        logic [5:0]  sec;
        logic [15:0] flags;
        logic [7:0]  lost;
        logic [31:0] cmp;
    } vec_t;

    // update + alarm (alarm at 00:00:12), interval 1024, armed at 2024
    localparam vec_t VECS [7] = '{
        '{32'd2024,  6'd10, 16'h0000, 8'd0, 32'd3048},
        '{32'd3048,  6'd11, 16'h0190, 8'd0, 32'd4072},
        '{32'd4072,  6'd11, 16'h0000, 8'd0, 32'd5096},
        '{32'd5096,  6'd12, 16'h01B0, 8'd0, 32'd6120},
        '{32'd6120,  6'd12, 16'h01A0, 8'd0, 32'd7144},
        '{32'd7154,  6'd13, 16'h0190, 8'd0, 32'd8168},
        '{32'd11240, 6'd13, 16'h0000, 8'd3, 32'd12264}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive counter and seconds, then watch twelve cycles for strobes
    task automatic apply(input logic [31:0] c, input logic [5:0] s);
        @(negedge clk);
        counter_in = c;
        sec_in = s;
        irq_seen = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (irq_strobe) irq_seen++;
        end
    endtask

    // same, but the acknowledge lands on the edge that latches the new flags
    task automatic apply_ack_at_latch(input logic [31:0] c, input logic [5:0] s);
        @(negedge clk);
        counter_in = c;
        sec_in = s;
        irq_seen = 0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        flag_ack = 1'b1;
        @(negedge clk);
        flag_ack = 1'b0;
        if (irq_strobe) irq_seen++;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (irq_strobe) irq_seen++;
        end
    endtask

    task automatic ack();
        @(negedge clk);
        flag_ack = 1'b1;
        @(negedge clk);
        flag_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        // R1 reset state
        check("R1 flag_word", 32'(flag_word), 32'h0);
        check("R1 irq_strobe", 32'(irq_strobe), 32'h0);
        check("R1 cmp_active", 32'(cmp_active), 32'h0);
        check("R1 cmp_value", cmp_value, 32'h0);
        check("R1 lost_ticks", 32'(lost_ticks), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 arming with base interval
        counter_in = 32'd1000;
        sec_in = 6'd10;
        alm_sec = 6'd12;
        upd_en = 1'b1;
        alm_en = 1'b1;
        wait_cyc(3);
        check("R2 cmp_active", 32'(cmp_active), 32'h1);
        check("R2 arm value", cmp_value, 32'd2024);

        // R4 R5 R6 R10 table walk
        for (int v = 0; v < 7; v++) begin
            apply(VECS[v].cnt, VECS[v].sec);
            check($sformatf("R5 R6 R10 vec%0d flags", v), 32'(flag_word), 32'(VECS[v].flags));
            check($sformatf("R10 vec%0d strobes", v), irq_seen, (VECS[v].flags != 0) ? 1 : 0);
            check($sformatf("R4 vec%0d lost", v), 32'(lost_ticks), 32'(VECS[v].lost));
            check($sformatf("R4 vec%0d cmp", v), cmp_value, VECS[v].cmp);
            ack();
        end

        // R11 sticky OR, then clear
        apply(32'd12264, 6'd14);
        check("R11 first flag", 32'(flag_word), 32'h0190);
        alm_sec = 6'd14;
        apply(32'd13288, 6'd14);
        check("R11 ored flags", 32'(flag_word), 32'h01B0);
        ack();
        check("R11 cleared", 32'(flag_word), 32'h0);

        // R11 acknowledge coinciding with new flag
        apply(32'd14312, 6'd15);
        check("R11 pending update", 32'(flag_word), 32'h0190);
        alm_sec = 6'd15;
        apply_ack_at_latch(32'd15336, 6'd15);
        check("R11 ack with new flag", 32'(flag_word), 32'h01A0);
        check("R11 strobe", irq_seen, 1);
        ack();

        // R3 all enables clear
        @(negedge clk);
        upd_en = 1'b0;
        alm_en = 1'b0;
        wait_cyc(2);
        check("R3 inactive", 32'(cmp_active), 32'h0);
        apply(32'd16360, 6'd16);
        check("R3 no strobe", irq_seen, 0);
        check("R3 flags unchanged", 32'(flag_word), 32'h0);

        // R7 slow periodic: k=5, flag every 2 ticks
        @(negedge clk);
        per_rate_log2 = 4'd5;
        counter_in = 32'd20000;
        per_en = 1'b1;
        wait_cyc(3);
        check("R2 periodic arm", cmp_value, 32'd21024);
        apply(32'd21024, 6'd16);
        check("R7 tick1 no flag", 32'(flag_word), 32'h0);
        apply(32'd22048, 6'd16);
        check("R7 tick2 flag", 32'(flag_word), 32'h01C0);
        ack();
        apply(32'd23072, 6'd16);
        check("R7 tick3 no flag", 32'(flag_word), 32'h0);
        apply(32'd24096, 6'd16);
        check("R7 tick4 flag", 32'(flag_word), 32'h01C0);
        ack();

        // R9 one lost tick completes the divide-by-two
        apply(32'd26144, 6'd16);
        check("R9 lost", 32'(lost_ticks), 32'd1);
        check("R9 credited flag", 32'(flag_word), 32'h01C0);
        check("R9 cmp", cmp_value, 32'd27168);
        ack();

        // R8 fast periodic: k=10, interval 64, flag every tick
        @(negedge clk);
        per_rate_log2 = 4'd10;
        apply(32'd27168, 6'd16);
        check("R8 fast flag a", 32'(flag_word), 32'h01C0);
        check("R8 fast cmp a", cmp_value, 32'd27232);
        ack();
        apply(32'd27232, 6'd16);
        check("R8 fast flag b", 32'(flag_word), 32'h01C0);
        check("R8 fast cmp b", cmp_value, 32'd27296);
        ack();

        // R8 arming at fastest rate: interval 8
        @(negedge clk);
        per_en = 1'b0;
        wait_cyc(2);
        per_rate_log2 = 4'd13;
        counter_in = 32'd30000;
        per_en = 1'b1;
        wait_cyc(3);
        check("R8 fast arm", cmp_value, 32'd30008);

        // R12 wrap-safe comparison
        @(negedge clk);
        per_en = 1'b0;
        wait_cyc(2);
        per_rate_log2 = 4'd6;
        counter_in = 32'hFFFF_FE00;
        upd_en = 1'b1;
        wait_cyc(3);
        check("R12 wrapped arm", cmp_value, 32'h0000_0200);
        apply(32'hFFFF_FF00, 6'd16);
        check("R12 no early tick", cmp_value, 32'h0000_0200);
        check("R12 no strobe", irq_seen, 0);
        apply(32'h0000_0200, 6'd16);
        check("R12 tick after wrap", cmp_value, 32'h0000_0600);
        check("R5 first record silent", 32'(flag_word), 32'h0);
        apply(32'h0000_0600, 6'd17);
        check("R5 update after wrap", 32'(flag_word), 32'h0190);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule